// File: doc/BRIEF.md
# Interleaved Successive-Approximation Converter Sequencer

This block is the digital controller for a time-interleaved converter made of eighteen identical successive-approximation sections. A single free-running phase counter drives a schedule in which each section follows the same eighteen-cycle program. The program steps are reference-zero sampling, auto-zero comparison, auto-calibration comparison, input sampling, thirteen binary-search decisions, and a transfer cycle. Neighbouring sections run one clock apart, so exactly one section takes the input on every clock.

Each section has its own comparator input and its own trial code output. The trial code drives that section's capacitive DAC during the search. An output selector watches the section in its transfer cycle and passes its 13-bit result through a correction stage. The correction stage rounds the result to a 12-bit word and saturates it at full scale. Words leave in the order in which their samples were taken, 14 clocks after the sample.

The analog parts (track-and-hold, comparators, references) are outside the block. The section count follows from the resolution: the number of sections is the resolution plus five, so the default of 13 bits gives 18 sections and 18 steps.

Top module: `tis_sequencer`

## Requirements
- R1: In the cycle that is t cycles after reset release (t = 0 is the first cycle), only bit t mod 18 of `sample_o` is set. Section 0 therefore samples first.
- R2: In cycle t, only one bit is set in each of four strobe vectors. For `ref_zero_o` it is bit (t+3) mod 18. For `auto_zero_o` it is bit (t+2) mod 18. For `auto_cal_o` it is bit (t+1) mod 18. For `xfer_o` it is bit (t+4) mod 18.
- R3: In the cycle after a section samples, that section's 13-bit field of `dac_code_o` equals 0x1000, which is the MSB trial alone. Section s uses bits [13s+12:13s].
- R4: The search resolves one bit per cycle, starting at the MSB. A comparator input of 1 sampled at the clock edge that ends a trial cycle means the input is at or above the trial code, and the trial bit is kept. A 0 clears the trial bit. After 13 decisions, the section's field holds the sampled value exactly.
- R5: The word for the sample taken in cycle t appears on `data_o` in cycle t+14.
- R6: For a 13-bit result r below 8191, `data_o` equals (r+1)/2 rounded down.
- R7: A result of 8191 gives `data_o` = 4095, the saturated value.
- R8: `data_valid_o` is low in cycles 0 to 13 after reset release. It is high from cycle 14 on and stays high until the next reset.
- R9: Asserting `rst_n` in the middle of a run forces `data_valid_o` low at once and puts sampling back on section 0. When reset is released, the R1 and R8 timing starts again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_i | input | 18 | Comparator decision of each section, 1 = input at or above trial |
| ref_zero_o | output | 18 | Section sampling the reference zero |
| auto_zero_o | output | 18 | Section doing its auto-zero comparison |
| auto_cal_o | output | 18 | Section doing its auto-calibration comparison |
| sample_o | output | 18 | Section tracking/sampling the input |
| xfer_o | output | 18 | Section presenting its result |
| dac_code_o | output | 234 | Trial code of each section, 13 bits per section |
| data_o | output | 12 | Corrected output word |
| data_valid_o | output | 1 | Output word is valid |

## Verification
The comparators are modelled as ideal: each one compares the value held by its section against the trial code it receives. First, every 13-bit code from 0 to 8191 is sent in ascending order, one per clock. This pass shows whether every decision bit is resolved and whether the rounding is right for both odd and even results. Next come sequences that jump between full scale, zero, mid-scale neighbours and alternating bit patterns. Because successive sections get unrelated values, these catch a selector that reads the wrong section or a word that arrives at the wrong latency, and they exercise the saturation case. A reset in the middle of a run, followed by a short descending ramp, checks that phase alignment and the fill-up of the valid flag start again.

// File: rtl/tis_pkg.sv
package tis_pkg;
  // Local step numbers of one section's program (0-based)
  localparam int unsigned ST_REFZ = 0;
  localparam int unsigned ST_AZ   = 1;
  localparam int unsigned ST_CAL  = 2;
  localparam int unsigned ST_SAMP = 3;
  localparam int unsigned ST_BIT0 = 4;  // first search decision
  localparam int unsigned OVERHEAD_STEPS = 5;  // non-search steps per program
endpackage

// File: rtl/tis_phase_gen.sv
module tis_phase_gen #(
  parameter int unsigned RES_BITS = 13
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  output logic [$clog2(RES_BITS+tis_pkg::OVERHEAD_STEPS)-1:0] phase_o,
  output logic                                     valid_o
);
  localparam int unsigned NSEC = RES_BITS + tis_pkg::OVERHEAD_STEPS;
  localparam int unsigned PW   = $clog2(NSEC);
  localparam int unsigned LAT  = RES_BITS + 1;
  localparam int unsigned FW   = $clog2(LAT + 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [FW-1:0] fill_q, fill_d;
  logic          fill_en;

  always_comb begin
    phase_d = (phase_q == PW'(NSEC - 1)) ? '0 : phase_q + 1'b1;
    fill_en = (fill_q != FW'(LAT));
    fill_d  = fill_q + 1'b1;
  end

  // Reset value places section 0 in its sampling step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PW'(tis_pkg::ST_SAMP);
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign phase_o = phase_q;
  assign valid_o = (fill_q == FW'(LAT));
endmodule

// File: rtl/tis_sar_slice.sv
module tis_sar_slice #(
  parameter int unsigned RES_BITS = 13,
  parameter int unsigned IDX      = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [$clog2(RES_BITS+tis_pkg::OVERHEAD_STEPS)-1:0] phase_i,
  input  logic                cmp_i,
  output logic                ref_zero_o,
  output logic                auto_zero_o,
  output logic                auto_cal_o,
  output logic                sample_o,
  output logic                xfer_o,
  output logic [RES_BITS-1:0] code_o
);
  import tis_pkg::*;
  localparam int unsigned NSEC = RES_BITS + OVERHEAD_STEPS;
  localparam int unsigned PW   = $clog2(NSEC);

  logic [PW-1:0]       step;
  logic [PW-1:0]       bit_idx;
  logic                in_search;
  logic                code_en;
  logic [RES_BITS-1:0] code_q, code_d;

  // Local step = phase minus this section's offset, modulo NSEC
  always_comb begin
    if (phase_i >= PW'(IDX)) step = phase_i - PW'(IDX);
    else                     step = phase_i + PW'(NSEC - IDX);
  end

  assign ref_zero_o  = (step == PW'(ST_REFZ));
  assign auto_zero_o = (step == PW'(ST_AZ));
  assign auto_cal_o  = (step == PW'(ST_CAL));
  assign sample_o    = (step == PW'(ST_SAMP));
  assign xfer_o      = (step == PW'(NSEC - 1));
  assign in_search   = (step >= PW'(ST_BIT0)) && (step < PW'(NSEC - 1));
  // bit under trial: MSB at first search step, LSB at last
  assign bit_idx     = PW'(RES_BITS - 1 + ST_BIT0) - step;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    if (sample_o) begin
      code_en = 1'b1;
      code_d  = {1'b1, {(RES_BITS-1){1'b0}}};
    end else if (in_search) begin
      code_en = 1'b1;
      for (int b = 0; b < RES_BITS; b++) begin
        if (PW'(b) == bit_idx && !cmp_i) code_d[b] = 1'b0;
        if (PW'(b + 1) == bit_idx)       code_d[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/tis_out_mux.sv
module tis_out_mux #(
  parameter int unsigned RES_BITS = 13
) (
  input  logic [$clog2(RES_BITS+tis_pkg::OVERHEAD_STEPS)-1:0] phase_i,
  input  logic [(RES_BITS+tis_pkg::OVERHEAD_STEPS)*RES_BITS-1:0] codes_i,
  output logic [RES_BITS-2:0] word_o
);
  localparam int unsigned NSEC = RES_BITS + tis_pkg::OVERHEAD_STEPS;
  localparam int unsigned PW   = $clog2(NSEC);

  logic [PW-1:0]       sel;
  logic [RES_BITS-1:0] sel_code;
  logic [RES_BITS-1:0] bumped;

  // Section in its transfer step is the one just ahead of the phase
  assign sel = (phase_i == PW'(NSEC - 1)) ? '0 : phase_i + 1'b1;

  always_comb begin
    sel_code = '0;
    for (int i = 0; i < NSEC; i++)
      if (sel == PW'(i)) sel_code = codes_i[i*RES_BITS +: RES_BITS];
  end

  // Round half up, saturate at full scale
  assign bumped = sel_code + 1'b1;
  assign word_o = (&sel_code) ? {(RES_BITS-1){1'b1}} : bumped[RES_BITS-1:1];
endmodule

// File: rtl/tis_sequencer.sv
module tis_sequencer #(
  parameter int unsigned RES_BITS = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [RES_BITS+4:0]            cmp_i,
  output logic [RES_BITS+4:0]            ref_zero_o,
  output logic [RES_BITS+4:0]            auto_zero_o,
  output logic [RES_BITS+4:0]            auto_cal_o,
  output logic [RES_BITS+4:0]            sample_o,
  output logic [RES_BITS+4:0]            xfer_o,
  output logic [(RES_BITS+5)*RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-2:0]            data_o,
  output logic                           data_valid_o
);
  localparam int unsigned NSEC = RES_BITS + tis_pkg::OVERHEAD_STEPS;
  localparam int unsigned PW   = $clog2(NSEC);

  logic [PW-1:0] phase;

  tis_phase_gen #(.RES_BITS(RES_BITS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase),
    .valid_o (data_valid_o)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    tis_sar_slice #(.RES_BITS(RES_BITS), .IDX(s)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_i     (phase),
      .cmp_i       (cmp_i[s]),
      .ref_zero_o  (ref_zero_o[s]),
      .auto_zero_o (auto_zero_o[s]),
      .auto_cal_o  (auto_cal_o[s]),
      .sample_o    (sample_o[s]),
      .xfer_o      (xfer_o[s]),
      .code_o      (dac_code_o[s*RES_BITS +: RES_BITS])
    );
  end

  tis_out_mux #(.RES_BITS(RES_BITS)) u_mux (
    .phase_i (phase),
    .codes_i (dac_code_o),
    .word_o  (data_o)
  );
endmodule

// File: rtl/tis_sequencer_chk.sv
module tis_sequencer_chk #(
  parameter int unsigned RES_BITS = 13
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [RES_BITS+4:0]            ref_zero_o,
  input logic [RES_BITS+4:0]            auto_zero_o,
  input logic [RES_BITS+4:0]            auto_cal_o,
  input logic [RES_BITS+4:0]            sample_o,
  input logic [RES_BITS+4:0]            xfer_o,
  input logic [(RES_BITS+5)*RES_BITS-1:0] dac_code_o,
  input logic                           data_valid_o
);
  localparam int unsigned NSEC = RES_BITS + 5;

  AST_SAMPLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sample_o) == 1); // R1
  AST_SAMPLE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sample_o == {$past(sample_o[NSEC-2:0]), $past(sample_o[NSEC-1])}); // R1
  AST_AZ_AFTER_REFZ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> auto_zero_o == $past(ref_zero_o)); // R2
  AST_CAL_AFTER_AZ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> auto_cal_o == $past(auto_zero_o)); // R2
  AST_SAMPLE_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sample_o == $past(auto_cal_o)); // R2
  AST_XFER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(xfer_o) == 1); // R2
  AST_MSB_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o[0] |=> dac_code_o[RES_BITS-1:0] == {1'b1, {(RES_BITS-1){1'b0}}}); // R3
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> data_valid_o); // R8
endmodule

bind tis_sequencer tis_sequencer_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_zero_o   (ref_zero_o),
  .auto_zero_o  (auto_zero_o),
  .auto_cal_o   (auto_cal_o),
  .sample_o     (sample_o),
  .xfer_o       (xfer_o),
  .dac_code_o   (dac_code_o),
  .data_valid_o (data_valid_o)
);

// File: tb/tis_sequencer_bench.sv
module tis_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RB   = 13;
  localparam int NS   = RB + 5;
  localparam int LAT  = RB + 1;
  localparam int MAXV = 9000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     cmp;
  logic [NS-1:0]     ref_zero, auto_zero, auto_cal, sample, xfer;
  logic [NS*RB-1:0]  dac_code;
  logic [RB-2:0]     data;
  logic              data_valid;

  int checks = 0;
  int errors = 0;
  int stim [MAXV];
  logic [RB-1:0] held [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tis_sequencer #(.RES_BITS(RB)) u_tis_sequencer (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
    .ref_zero_o(ref_zero), .auto_zero_o(auto_zero), .auto_cal_o(auto_cal),
    .sample_o(sample), .xfer_o(xfer), .dac_code_o(dac_code),
    .data_o(data), .data_valid_o(data_valid)
  );

  // Ideal comparators: held value at or above trial code
  always_comb
    for (int s = 0; s < NS; s++)
      cmp[s] = (held[s] >= dac_code[s*RB +: RB]);

  function automatic int expect_word(input int r);
    if (r == 8191) return 4095;
    return (r + 1) / 2;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [NS-1:0] bit_at(input int i);
    return NS'(1) << (i % NS);
  endfunction

  // Runs ncyc cycles after a reset release made at a falling edge
  task automatic run(input int ncyc);
    for (int t = 0; t < ncyc; t++) begin
      #1;
      check("R1 sample", int'(sample), int'(bit_at(t)));
      check("R2 ref_zero", int'(ref_zero), int'(bit_at(t + 3)));
      check("R2 auto_zero", int'(auto_zero), int'(bit_at(t + 2)));
      check("R2 auto_cal", int'(auto_cal), int'(bit_at(t + 1)));
      check("R2 xfer", int'(xfer), int'(bit_at(t + 4)));
      check("R8 valid", int'(data_valid), (t >= LAT) ? 1 : 0);
      if (t >= 1)
        check("R3 msb trial", int'(dac_code[((t - 1) % NS)*RB +: RB]), 4096);
      if (t >= LAT) begin
        if (stim[t - LAT] == 8191)
          check("R7 saturate (R4 R5)", int'(data), expect_word(stim[t - LAT]));
        else if (stim[t - LAT] % 2 == 1)
          check("R6 round (R4 R5)", int'(data), expect_word(stim[t - LAT]));
        else
          check("R4 R5 word", int'(data), expect_word(stim[t - LAT]));
      end
      held[t % NS] = RB'(stim[t]);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) held[s] = '0;
    // Pattern 1: every code ascending, then corner mix
    for (int i = 0; i < 8192; i++) stim[i] = i;
    for (int i = 8192; i < MAXV; i++) begin
      case (i % 8)
        0: stim[i] = 8191;
        1: stim[i] = 0;
        2: stim[i] = 4095;
        3: stim[i] = 4096;
        4: stim[i] = 'h1555;
        5: stim[i] = 'h0AAA;
        6: stim[i] = 8190;
        default: stim[i] = 1;
      endcase
    end
    repeat (3) @(negedge clk);
    #1;
    check("R8 valid in reset", int'(data_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(8192 + 300);
    // Mid-run reset
    rst_n = 1'b0;
    #1;
    check("R9 valid drops", int'(data_valid), 0);
    check("R9 section 0 sampling", int'(sample), 1);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 200; i++) stim[i] = 8191 - 37 * i;
    rst_n = 1'b1;
    run(200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule